// File: doc/BRIEF.md
# Serial RAM Download Engine

This block is the target end of a byte-serial download sequence. Once a `start` pulse arms it, it takes bytes from an upstream receiver: a 32-bit destination address and a 16-bit length, then a header check byte. If the header passes, it takes the payload and writes it into RAM through a byte-wide write strobe. A final check byte follows. Every checkpoint answers with one response byte on the transmit stream: 0x10 means accepted, 0x11 means a checksum or range failure, and 0x18 means a receive error. Any answer other than 0x10 drops the engine back to idle.

Both byte streams use valid/ready. A receive byte transfers on a clock edge where `rx_valid` and `rx_ready` are both high. The engine lowers `rx_ready` while it is idle and while a response byte is waiting, so the upstream receiver must hold its byte until `rx_ready` returns. A response byte stays on `tx_data` with `tx_valid` high until the edge where `tx_ready` is high. After the final acceptance has been transferred, the engine raises `jump_req` for one cycle, with `jump_addr` holding the received destination address.

Top module: `ramload_engine`

## Requirements
- R1: The address is assembled from four bytes, received most significant first (bits 31..24 down to 7..0). The length is assembled from two bytes, bits 15..8 first. `jump_addr` shows the assembled address.
- R2: An address or length byte received without error produces no response byte. `rx_ready` and `tx_valid` are never high in the same cycle.
- R3: An address or length byte received with `rx_err` high produces response 0x18, after which the engine is idle (`rx_ready` low).
- R4: A check byte passes when the 8-bit sum of the bytes it covers plus the check byte is zero modulo 256. The header check covers the six address and length bytes. The payload check covers all payload bytes.
- R5: At the header check byte, `rx_err` gives 0x18. A sum mismatch or a range violation gives 0x11. Both end in idle. A pass gives 0x10 and the payload phase follows.
- R6: The range is valid when the address is at least RAM_BASE and address plus length is no greater than RAM_TOP+1.
- R7: Payload byte k is written to address start+k, with `wr_en` high for one cycle on the cycle after the byte is accepted. A payload byte with `rx_err` high is not written; it produces 0x18 and the engine goes idle.
- R8: A length of zero moves directly from the header acceptance to the payload check byte.
- R9: At the payload check byte, the response codes follow the same rules as R5. After 0x10 is transferred, `jump_req` is high for exactly one cycle. No jump is issued on any other outcome.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R11: While idle, `rx_ready` stays low, so bytes offered upstream are neither consumed nor answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms the engine when it is idle |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine can take a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_err | input | 1 | Receive error attached to the byte |
| tx_valid | output | 1 | Response byte valid |
| tx_ready | input | 1 | Downstream takes the response byte |
| tx_data | output | 8 | Response code |
| wr_en | output | 1 | RAM byte write strobe |
| wr_addr | output | 32 | RAM write address |
| wr_data | output | 8 | RAM write data |
| jump_req | output | 1 | One-cycle branch request |
| jump_addr | output | 32 | Branch target (received start address) |

## Verification
The hardest states to reach from the ports are an error or a corrupted check byte at one specific position in a long session, and a transfer that ends exactly at RAM_TOP. The bench drives whole sessions through a single task. That task takes the error position, the checksum corruption and the payload error position as arguments, so directed calls can place an error on each header byte, make a block end exactly at the RAM top, and send a zero-length transfer. Seeded random sessions then mix addresses just below the base, lengths that overrun the RAM top, and random back-pressure on the transmit stream.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CNT, ST_HSUM, ST_DATA, ST_PSUM, ST_RESP
  } rl_state_e;

  typedef enum logic [1:0] {
    AFT_IDLE, AFT_DATA, AFT_PSUM, AFT_JUMP
  } rl_after_e;

  localparam logic [7:0] ACK_OK  = 8'h10;
  localparam logic [7:0] ACK_BAD = 8'h11;
  localparam logic [7:0] ACK_ERR = 8'h18;
endpackage

// File: rtl/rl_csum.sv
module rl_csum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add,
  input  logic [W-1:0] din,
  input  logic [W-1:0] chk,
  output logic         match
);
  logic [W-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum_q <= '0;
    else if (clr) sum_q <= '0;
    else if (add) sum_q <= sum_q + din;
  end

  // covered bytes plus check byte must wrap to zero
  assign match = ((sum_q + chk) == '0);
endmodule

// File: rtl/rl_window.sv
module rl_window #(
  parameter int              ADDR_W   = 32,
  parameter int              CNT_W    = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h2000_0400,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 32'h2000_07FF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic              ok
);
  localparam int XW = ADDR_W + 1;
  logic [XW-1:0] end_x;
  logic [XW-1:0] lim_x;

  assign end_x = {1'b0, addr} + XW'(cnt);
  assign lim_x = {1'b0, RAM_TOP} + XW'(1);
  assign ok    = (addr >= RAM_BASE) && (end_x <= lim_x);
endmodule

// File: rtl/rl_resp_hold.sv
module rl_resp_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] code,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= code;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  assign done = tx_valid && tx_ready;
endmodule

// File: rtl/ramload_engine.sv
module ramload_engine
  import rl_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                CNT_W    = 16,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h2000_0400,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 32'h2000_07FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              jump_req,
  output logic [ADDR_W-1:0] jump_addr
);
  localparam int ABYTES = ADDR_W / 8;
  localparam int CBYTES = CNT_W / 8;
  localparam int IDX_W  = (ABYTES > 1) ? $clog2(ABYTES) : 1;

  rl_state_e         state_q;
  rl_after_e         after_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic [CNT_W-1:0]  cnt_q, rem_q;

  logic      take, sum_ok, win_ok, tx_done;
  logic      resp_load;
  logic [7:0] resp_code;
  rl_after_e resp_after;
  logic      sum_clr, sum_add;

  assign rx_ready = (state_q == ST_ADDR) || (state_q == ST_CNT) ||
                    (state_q == ST_HSUM) || (state_q == ST_DATA) ||
                    (state_q == ST_PSUM);
  assign take     = rx_valid && rx_ready;
  assign jump_addr = addr_q;

  assign sum_clr = ((state_q == ST_IDLE) && start) || ((state_q == ST_HSUM) && take);
  assign sum_add = take && !rx_err &&
                   ((state_q == ST_ADDR) || (state_q == ST_CNT) || (state_q == ST_DATA));

  rl_csum #(.W(8)) csum_i (
    .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add(sum_add),
    .din(rx_data), .chk(rx_data), .match(sum_ok)
  );

  rl_window #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP)) win_i (
    .addr(addr_q), .cnt(cnt_q), .ok(win_ok)
  );

  rl_resp_hold resp_i (
    .clk(clk), .rst_n(rst_n), .load(resp_load), .code(resp_code),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .done(tx_done)
  );

  // response decision for the byte accepted this cycle
  always_comb begin
    resp_load  = 1'b0;
    resp_code  = ACK_OK;
    resp_after = AFT_IDLE;
    if (take) begin
      if (rx_err) begin
        resp_load = 1'b1;
        resp_code = ACK_ERR;
      end else if (state_q == ST_HSUM) begin
        resp_load = 1'b1;
        if (sum_ok && win_ok) begin
          resp_after = (cnt_q == '0) ? AFT_PSUM : AFT_DATA;
        end else begin
          resp_code = ACK_BAD;
        end
      end else if (state_q == ST_PSUM) begin
        resp_load = 1'b1;
        if (sum_ok) resp_after = AFT_JUMP;
        else        resp_code  = ACK_BAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      after_q  <= AFT_IDLE;
      idx_q    <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      ptr_q    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= 8'h00;
      jump_req <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      jump_req <= 1'b0;
      if (resp_load) begin
        state_q <= ST_RESP;
        after_q <= resp_after;
        if (state_q == ST_HSUM) begin
          rem_q <= cnt_q;
          ptr_q <= addr_q;
        end
      end else begin
        case (state_q)
          ST_IDLE: if (start) begin
            state_q <= ST_ADDR;
            idx_q   <= '0;
          end
          ST_ADDR: if (take) begin
            addr_q <= {addr_q[ADDR_W-9:0], rx_data};
            if (idx_q == IDX_W'(ABYTES - 1)) begin
              idx_q   <= '0;
              state_q <= ST_CNT;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_CNT: if (take) begin
            cnt_q <= {cnt_q[CNT_W-9:0], rx_data};
            if (idx_q == IDX_W'(CBYTES - 1)) begin
              idx_q   <= '0;
              state_q <= ST_HSUM;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_DATA: if (take) begin
            wr_en   <= 1'b1;
            wr_addr <= ptr_q;
            wr_data <= rx_data;
            ptr_q   <= ptr_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) state_q <= ST_PSUM;
          end
          ST_RESP: if (tx_done) begin
            case (after_q)
              AFT_DATA: state_q <= ST_DATA;
              AFT_PSUM: state_q <= ST_PSUM;
              AFT_JUMP: begin
                state_q  <= ST_IDLE;
                jump_req <= 1'b1;
              end
              default:  state_q <= ST_IDLE;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ramload_checker.sv
module ramload_checker #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h2000_0400,
  parameter logic [ADDR_W-1:0] RAM_TOP  = 32'h2000_07FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              jump_req
);
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ready && tx_valid));

  assert_wr_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_addr >= RAM_BASE) && (wr_addr <= RAM_TOP)));

  assert_jump_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> $past(tx_valid && tx_ready && (tx_data == 8'h10)));

  assert_jump_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |=> !jump_req);
endmodule

bind ramload_engine ramload_checker #(
  .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_TOP(RAM_TOP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .wr_en(wr_en), .wr_addr(wr_addr),
  .jump_req(jump_req)
);

// File: tb/ramload_engine_tb_top.sv
module ramload_engine_tb_top;
  localparam logic [31:0] BASE = 32'h2000_0400;
  localparam logic [31:0] TOP  = 32'h2000_07FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rx_valid = 1'b0, rx_err = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, wr_en, jump_req;
  logic [7:0] tx_data, wr_data;
  logic [31:0] wr_addr, jump_addr;

  always #10 clk = ~clk;

  ramload_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_err(rx_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .jump_req(jump_req), .jump_addr(jump_addr)
  );

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, jump_cnt = 0;
  logic [31:0] last_jump = '0;
  logic [7:0] mem [0:1023];
  logic [7:0] pay [0:63];

  always @(posedge clk) begin
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (wr_addr >= BASE && wr_addr <= TOP) mem[wr_addr - BASE] <= wr_data;
    end
    if (jump_req) begin
      jump_cnt  <= jump_cnt + 1;
      last_jump <= jump_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit err);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; rx_err = err;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
  endtask

  task automatic expect_resp(input logic [7:0] exp, input string req);
    int w = 0;
    logic [7:0] first;
    while (!tx_valid && w < 20) begin @(negedge clk); w++; end
    chk(tx_valid, req, {31'b0, tx_valid}, 32'h1);
    first = tx_data;
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(tx_valid && tx_data == first, "R10", tx_data, first);
    end
    tx_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_ready = 1'b0;
    chk(first == exp, req, first, exp);
  endtask

  function automatic bit in_range(input logic [31:0] a, input logic [15:0] n);
    longint e = longint'(a) + longint'(n);
    return (a >= BASE) && (e <= longint'(TOP) + 1);
  endfunction

  // herr: header position 0..6 with error (-1 none); perr: payload position 0..n (n = check byte)
  task automatic session(input logic [31:0] a, input logic [15:0] n, input int herr,
                         input logic [7:0] hdelta, input int perr, input logic [7:0] pdelta);
    logic [7:0] hdr [0:5];
    logic [7:0] s = 8'h00;
    logic [7:0] exp;
    int w0 = wr_cnt, j0 = jump_cnt, bad = 0;
    hdr[0] = a[31:24]; hdr[1] = a[23:16]; hdr[2] = a[15:8]; hdr[3] = a[7:0];
    hdr[4] = n[15:8];  hdr[5] = n[7:0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      send_byte(hdr[i], herr == i);
      s = s + hdr[i];
      if (herr == i) begin
        expect_resp(8'h18, "R3");
        chk(!rx_ready, "R3", {31'b0, rx_ready}, 32'h0);
        return;
      end
      chk(!tx_valid, "R2", {31'b0, tx_valid}, 32'h0);
    end
    send_byte(8'h00 - s + hdelta, herr == 6);
    exp = (herr == 6) ? 8'h18 : ((hdelta == 0 && in_range(a, n)) ? 8'h10 : 8'h11);
    expect_resp(exp, (exp == 8'h11 && hdelta == 0) ? "R6" : "R5");
    if (exp != 8'h10) begin
      chk(!rx_ready, "R5", {31'b0, rx_ready}, 32'h0);
      chk(wr_cnt == w0, "R5", wr_cnt - w0, 0);
      return;
    end
    s = 8'h00;
    for (int k = 0; k < int'(n); k++) begin
      pay[k] = 8'($urandom);
      send_byte(pay[k], perr == k);
      if (perr == k) begin
        expect_resp(8'h18, "R7");
        @(negedge clk);
        chk(wr_cnt - w0 == k, "R7", wr_cnt - w0, k);
        chk(!rx_ready, "R7", {31'b0, rx_ready}, 32'h0);
        return;
      end
      s = s + pay[k];
    end
    send_byte(8'h00 - s + pdelta, perr == int'(n));
    exp = (perr == int'(n)) ? 8'h18 : ((pdelta == 0) ? 8'h10 : 8'h11);
    expect_resp(exp, (n == 0) ? "R8" : "R9");
    @(negedge clk); @(negedge clk);
    chk(jump_cnt - j0 == ((exp == 8'h10) ? 1 : 0), "R9", jump_cnt - j0, (exp == 8'h10) ? 1 : 0);
    if (exp == 8'h10) chk(last_jump == a, "R1", last_jump, a);
    chk(wr_cnt - w0 == int'(n), "R7", wr_cnt - w0, n);
    for (int k = 0; k < int'(n); k++) if (mem[a - BASE + k] != pay[k]) bad++;
    chk(bad == 0, "R7", bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_ready && !tx_valid && !wr_en && !jump_req, "R11",
        {28'b0, rx_ready, tx_valid, wr_en, jump_req}, 0);
    // R11: bytes offered while idle are not taken
    rx_valid = 1'b1; rx_data = 8'h5A;
    repeat (5) @(negedge clk);
    chk(!rx_ready && !tx_valid, "R11", {30'b0, rx_ready, tx_valid}, 0);
    rx_valid = 1'b0;
    chk(wr_cnt == 0, "R11", wr_cnt, 0);

    session(32'h2000_0400, 16'd5, -1, 8'h00, -1, 8'h00);   // R1 good load
    session(32'h2000_0510, 16'd0, -1, 8'h00, -1, 8'h00);   // R8 zero length
    session(32'h2000_0600, 16'd0, -1, 8'h00, -1, 8'h01);   // R8 bad check, no payload
    for (int p = 0; p < 7; p++)
      session(32'h2000_0440, 16'd3, p, 8'h00, -1, 8'h00);  // R3/R5 error position sweep
    session(32'h2000_0440, 16'd3, -1, 8'h01, -1, 8'h00);   // R4/R5 header mismatch
    session(32'h2000_03FF, 16'd1, -1, 8'h00, -1, 8'h00);   // R6 below base
    session(32'h2000_07FC, 16'd5, -1, 8'h00, -1, 8'h00);   // R6 overrun
    session(32'h2000_07FC, 16'd4, -1, 8'h00, -1, 8'h00);   // R6 exact fit at top
    session(32'h2000_0480, 16'd4, -1, 8'h00, 2, 8'h00);    // R7 payload byte error
    session(32'h2000_0480, 16'd4, -1, 8'h00, 4, 8'h00);    // R9 error on check byte
    session(32'h2000_0480, 16'd4, -1, 8'h00, -1, 8'h80);   // R9 mismatch

    for (int r = 0; r < 40; r++) begin
      int mode = $urandom % 8;
      logic [15:0] n = 16'($urandom % 41);
      logic [31:0] a = BASE - 32'd8 + 32'($urandom % 1040);
      session(a, n,
              (mode == 4) ? int'($urandom % 7) : -1,
              (mode == 5) ? 8'(1 + $urandom % 255) : 8'h00,
              (mode == 6) ? int'($urandom % (int'(n) + 1)) : -1,
              (mode == 7) ? 8'(1 + $urandom % 255) : 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule